// File: doc/BRIEF.md
# Modem Handshake Control and Loopback

This block sits beside a UART data path and owns the modem handshake lines. A host writes a control register whose bits drive four active-low output pins: request-to-send, data-terminal-ready and two general-purpose lines. A fifth bit selects a loopback diagnostic mode. The block watches four active-low inputs: clear-to-send, data-set-ready, ring and carrier detect. Each input passes through a synchronizer. The block reports the present state of each input in a status register, together with sticky change flags.

In loopback mode, the serial output pin is parked at mark (logic 1). The transmitter's serial stream is turned back into the receiver's serial input. The four control bits stand in for the four monitored inputs, and the external handshake pins are forced to their inactive (high) level. This lets software exercise the whole handshake and status path without any cable attached. A single request output tells the interrupt logic that at least one change flag is pending. A read of the status register acknowledges the flags.

Top module: `modem_ctl_top`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), the control register reads 0x00, the status register reads 0x00 while all input pins are high, every handshake output pin is high and msi_req is 0.
- R2: A write (wr_en=1, reg_sel=0) stores wdata[4:0] at that clock edge. Bit 0 drives rts_n, bit 1 drives dtr_n, bit 2 drives gp1_n and bit 3 drives gp2_n, and a stored 1 drives its pin low outside loopback. A control read returns {3'b000, stored bits}.
- R3: Status bits 4, 5, 6 and 7 show the present state of CTS, DSR, RI and DCD, with 1 meaning the pin is low. A pin change is visible in them after two clock edges (two-flop synchronizer).
- R4: Status bits 0 (CTS), 1 (DSR) and 3 (DCD) are sticky flags that set on every change of the matching present state, one edge after the present bit changes.
- R5: Status bit 2 (RI change) sets only when the ring state goes from active to inactive, never when ring becomes active.
- R6: A status read strobe (rd_en=1, reg_sel=1) returns the current flags on rdata in that cycle and clears all four flags at that edge.
- R7: A change that is detected at the same edge as a clearing status read leaves its flag set, while the flags it does not touch are cleared.
- R8: msi_req is 1 exactly when at least one of the four change flags is set.
- R9: With control bit 4 set, sout_pin is 1, rx_serial_out equals tx_serial_in, and rts_n, dtr_n, gp1_n and gp2_n are all 1 whatever the other control bits hold.
- R10: In loopback, control bits RTS, DTR, GP1 and GP2 appear without delay as present CTS, DSR, RI and DCD, and drive the change flags under the rules of R4 and R5.
- R11: Outside loopback, sout_pin equals tx_serial_in and rx_serial_out equals sin_pin.
- R12: A read strobe with reg_sel=0 leaves the change flags unchanged.
- R13: A write with reg_sel=1 is ignored: both registers keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_sel | input | 1 | Register select: 0 control, 1 status |
| wr_en | input | 1 | Write strobe, one cycle |
| rd_en | input | 1 | Read strobe, one cycle |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the selected register (combinational) |
| tx_serial_in | input | 1 | Serial stream from the transmitter |
| rx_serial_out | output | 1 | Serial stream to the receiver |
| sout_pin | output | 1 | Serial output pin |
| sin_pin | input | 1 | Serial input pin |
| rts_n | output | 1 | Request-to-send, active low |
| dtr_n | output | 1 | Data-terminal-ready, active low |
| gp1_n | output | 1 | General-purpose output 1, active low |
| gp2_n | output | 1 | General-purpose output 2, active low |
| cts_n | input | 1 | Clear-to-send, active low |
| dsr_n | input | 1 | Data-set-ready, active low |
| ri_n | input | 1 | Ring indicator, active low |
| dcd_n | input | 1 | Carrier detect, active low |
| msi_req | output | 1 | Modem-status change request |

## Verification
Change detection and the acknowledging read can meet in one cycle. The bench sets one flag, then writes a loopback control value that asserts a second line. In the very next cycle it issues a status read strobe, so the new change is detected at the same edge that clears the flags. It judges the result by reading rdata during the strobe, which must show only the old flag, and by checking afterwards that only the new flag remains set and msi_req stays high.

// File: rtl/modem_pkg.sv
// Shared constants for the modem handshake block.
// Line order on internal vectors: 0 CTS, 1 DSR, 2 RI, 3 DCD.
package modem_pkg;
    localparam int N_LINES   = 4;
    localparam int LINE_CTS  = 0;
    localparam int LINE_DSR  = 1;
    localparam int LINE_RI   = 2;
    localparam int LINE_DCD  = 3;
    localparam int CTRL_W    = 5;
    localparam int CTRL_LOOP = 4;
    localparam int DATA_W    = 8;

    typedef enum logic {
        SEL_CTRL = 1'b0,
        SEL_STAT = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/modem_sync.sv
// Multi-stage synchronizer for asynchronous pins.
// Assumes STAGES >= 2; the reset value matches the pins' idle level.
module modem_sync #(
    parameter int              WIDTH     = 4,
    parameter int              STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    // Shift the pin sample through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= {STAGES{RESET_VAL}};
        end else begin
            stage_q[0] <= d_i;
            for (int s = 1; s < STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/modem_ctrl_reg.sv
// Host-writable control register. Assumes writes are one-cycle strobes;
// a write aimed at the other register is dropped.
module modem_ctrl_reg
    import modem_pkg::*;
#(
    parameter int W = CTRL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  reg_sel_e      sel,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  ctrl_q
);
    // Capture write data when the control register is addressed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_en && sel == SEL_CTRL) begin
            ctrl_q <= wdata;
        end
    end

    p_ctrl_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_CTRL) |=> (ctrl_q == $past(wdata)));

    p_stat_wr_ign_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_STAT) |=> $stable(ctrl_q));
endmodule

// File: rtl/modem_delta.sv
// Sticky change flags per monitored line. Lines marked in TRAIL_MASK
// flag only the active-to-inactive transition. A set in the same cycle
// as a clear wins, so no change is lost.
module modem_delta #(
    parameter int               WIDTH      = 4,
    parameter logic [WIDTH-1:0] TRAIL_MASK = 4'b0100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] cur_i,
    input  logic             clr_i,
    output logic [WIDTH-1:0] flag_o
);
    logic [WIDTH-1:0] prev_q;
    logic [WIDTH-1:0] flag_q;
    logic [WIDTH-1:0] set_w;

    // Remember the state seen in the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= cur_i;
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_line
        if (TRAIL_MASK[i]) begin : g_trail
            // Flag only when the line drops from active to inactive.
            assign set_w[i] = prev_q[i] && !cur_i[i];

            p_trail_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(flag_q[i]) |-> ($past(prev_q[i]) && !$past(cur_i[i])));
        end else begin : g_any
            // Flag on either transition.
            assign set_w[i] = prev_q[i] ^ cur_i[i];
        end

        // Sticky flag with set priority over clear.
        always_ff @(posedge clk) begin
            if (!rst_n) flag_q[i] <= 1'b0;
            else        flag_q[i] <= set_w[i] | (flag_q[i] & ~clr_i);
        end

        p_flag_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_q[i] && !clr_i) |=> flag_q[i]);
    end

    assign flag_o = flag_q;

    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !(|set_w)) |=> (flag_q == '0));
endmodule

// File: rtl/modem_ctl_top.sv
// Modem handshake control, status with change detection, and loopback.
// Assumes pins are asynchronous to clk and idle high; rdata is
// combinational from the selected register.
module modem_ctl_top
    import modem_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_sel,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              tx_serial_in,
    output logic              rx_serial_out,
    output logic              sout_pin,
    input  logic              sin_pin,
    output logic              rts_n,
    output logic              dtr_n,
    output logic              gp1_n,
    output logic              gp2_n,
    input  logic              cts_n,
    input  logic              dsr_n,
    input  logic              ri_n,
    input  logic              dcd_n,
    output logic              msi_req
);
    localparam logic [N_LINES-1:0] RI_MASK = N_LINES'(1) << LINE_RI;

    reg_sel_e           sel;
    logic [CTRL_W-1:0]  ctrl_q;
    logic [N_LINES-1:0] pins_n;
    logic [N_LINES-1:0] pins_sync_n;
    logic [N_LINES-1:0] cur_state;
    logic [N_LINES-1:0] flags;
    logic               loop_on;
    logic               stat_clr;
    logic               unused_wdata;

    assign sel          = reg_sel_e'(reg_sel);
    assign unused_wdata = ^wdata[DATA_W-1:CTRL_W];
    assign loop_on      = ctrl_q[CTRL_LOOP];
    assign stat_clr     = rd_en && sel == SEL_STAT;
    assign pins_n       = {dcd_n, ri_n, dsr_n, cts_n};

    modem_ctrl_reg #(.W(CTRL_W)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .sel    (sel),
        .wdata  (wdata[CTRL_W-1:0]),
        .ctrl_q (ctrl_q)
    );

    modem_sync #(.WIDTH(N_LINES), .STAGES(SYNC_STAGES), .RESET_VAL('1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pins_n),
        .q_o   (pins_sync_n)
    );

    // Present line state: control bits in loopback, inverted pins otherwise.
    always_comb begin
        if (loop_on) cur_state = ctrl_q[N_LINES-1:0];
        else         cur_state = ~pins_sync_n;
    end

    modem_delta #(.WIDTH(N_LINES), .TRAIL_MASK(RI_MASK)) u_delta (
        .clk    (clk),
        .rst_n  (rst_n),
        .cur_i  (cur_state),
        .clr_i  (stat_clr),
        .flag_o (flags)
    );

    // Handshake pins: inverted control bits, parked high in loopback.
    always_comb begin
        rts_n = loop_on | ~ctrl_q[0];
        dtr_n = loop_on | ~ctrl_q[1];
        gp1_n = loop_on | ~ctrl_q[2];
        gp2_n = loop_on | ~ctrl_q[3];
    end

    // Serial routing: mark on the pin and transmit turned back in loopback.
    always_comb begin
        sout_pin      = loop_on ? 1'b1 : tx_serial_in;
        rx_serial_out = loop_on ? tx_serial_in : sin_pin;
    end

    // Read mux for the two registers.
    always_comb begin
        if (sel == SEL_STAT) rdata = {cur_state, flags};
        else                 rdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
    end

    assign msi_req = |flags;

    p_loop_park_r9: assert property (@(posedge clk) disable iff (!rst_n)
        loop_on |-> (sout_pin && rts_n && dtr_n && gp1_n && gp2_n
                     && rx_serial_out == tx_serial_in));

    p_normal_route_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !loop_on |-> (sout_pin == tx_serial_in && rx_serial_out == sin_pin));

    p_msi_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (msi_req && !stat_clr) |=> msi_req);

    p_ctrl_rd_keep_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel == SEL_CTRL && msi_req) |=> msi_req);
endmodule

// File: tb/modem_ctl_top_bench.sv
module modem_ctl_top_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       tx_serial_in = 1'b1, sin_pin = 1'b1;
    logic       rx_serial_out, sout_pin;
    logic       rts_n, dtr_n, gp1_n, gp2_n;
    logic       cts_n = 1'b1, dsr_n = 1'b1, ri_n = 1'b1, dcd_n = 1'b1;
    logic       msi_req;
    int         n_checks = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    // Loopback walk: {control value, expected status read during strobe}.
    localparam logic [15:0] LOOP_VEC [8] = '{
        16'h1000, 16'h1111, 16'h1332, 16'h1770,
        16'h1FF8, 16'h1BB4, 16'h100B, 16'h1000
    };

    modem_ctl_top u_modem_ctl_top (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .tx_serial_in(tx_serial_in),
        .rx_serial_out(rx_serial_out), .sout_pin(sout_pin), .sin_pin(sin_pin),
        .rts_n(rts_n), .dtr_n(dtr_n), .gp1_n(gp1_n), .gp2_n(gp2_n),
        .cts_n(cts_n), .dsr_n(dsr_n), .ri_n(ri_n), .dcd_n(dcd_n), .msi_req(msi_req)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic do_write(input logic sel, input logic [7:0] v);
        reg_sel = sel; wr_en = 1'b1; wdata = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_strobe(input logic sel, output logic [7:0] v);
        reg_sel = sel; rd_en = 1'b1;
        #1 v = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic peek(input logic sel, output logic [7:0] v);
        reg_sel = sel;
        #1 v = rdata;
    endtask

    task automatic pins_out(output logic [7:0] v);
        v = {3'b000, sout_pin, gp2_n, gp1_n, dtr_n, rts_n};
    endtask

    initial begin
        logic [7:0] v;
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R1: reset state
        peek(1'b0, v); check("R1 ctrl", v, 8'h00);
        peek(1'b1, v); check("R1 status", v, 8'h00);
        pins_out(v);   check("R1 pins", v, 8'h1F);
        check("R1 msi", {7'd0, msi_req}, 8'h00);

        // R9/R10/R4/R5/R6/R8: table walk in loopback
        for (int i = 0; i < 8; i++) begin
            do_write(1'b0, LOOP_VEC[i][15:8]);
            tick(1);
            check("R8 msi", {7'd0, msi_req}, {7'd0, |LOOP_VEC[i][3:0]});
            pins_out(v);
            check("R9 pins parked", v, 8'h1F);
            read_strobe(1'b1, v);
            check("R10 status", v, LOOP_VEC[i][7:0]);
            peek(1'b1, v);
            check("R6 cleared", v[3:0], 8'h00);
        end
        tx_serial_in = 1'b0; #1;
        check("R9 loop serial", {6'd0, sout_pin, rx_serial_out}, 8'h02);
        tx_serial_in = 1'b1;

        // R7: change detected on the same edge as a clearing read
        do_write(1'b0, 8'h12);
        tick(1);
        do_write(1'b0, 8'h13);
        read_strobe(1'b1, v);
        check("R7 strobe value", v, 8'h32);
        peek(1'b1, v);
        check("R7 set wins", v, 8'h31);
        check("R7 msi", {7'd0, msi_req}, 8'h01);

        // R12: control read keeps flags
        read_strobe(1'b0, v);
        check("R12 ctrl read", v, 8'h13);
        peek(1'b1, v);
        check("R12 flags kept", v, 8'h31);

        // R13: write to status is ignored
        do_write(1'b1, 8'h00);
        peek(1'b0, v); check("R13 ctrl kept", v, 8'h13);
        peek(1'b1, v); check("R13 status kept", v, 8'h31);

        // Leave loopback, drive pins (R2, R11)
        do_write(1'b0, 8'h0F);
        tick(1);
        read_strobe(1'b1, v);
        peek(1'b1, v); check("R6 clear after exit", v, 8'h00);
        pins_out(v);   check("R2 pins low", v, 8'h10);
        peek(1'b0, v); check("R2 readback", v, 8'h0F);
        tx_serial_in = 1'b0; sin_pin = 1'b0; #1;
        check("R11 normal serial", {6'd0, sout_pin, rx_serial_out}, 8'h00);
        tx_serial_in = 1'b1; sin_pin = 1'b1;

        // R3/R4: CTS pin through synchronizer
        cts_n = 1'b0;
        tick(2);
        peek(1'b1, v); check("R3 present after sync", v, 8'h10);
        tick(1);
        peek(1'b1, v); check("R4 cts flag", v, 8'h11);

        // R5: ring assertion does not flag
        ri_n = 1'b0;
        tick(3);
        peek(1'b1, v); check("R5 no flag on ring", v, 8'h51);
        read_strobe(1'b1, v);
        peek(1'b1, v); check("R6 clear", v, 8'h50);
        ri_n = 1'b1;
        tick(3);
        peek(1'b1, v); check("R5 trailing ring", v, 8'h14);

        // R4: DSR and DCD together
        dsr_n = 1'b0; dcd_n = 1'b0;
        tick(3);
        peek(1'b1, v); check("R4 dsr dcd", v, 8'hBE);
        read_strobe(1'b1, v);
        check("R6 strobe value", v, 8'hBE);
        peek(1'b1, v); check("R6 final clear", v, 8'hB0);
        check("R8 msi low", {7'd0, msi_req}, 8'h00);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_checks++; n_fail++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule